// File: doc/BRIEF.md
# PCI Interrupt Pin Route Table

This block holds the table that decides which of eight shared interrupt lines (PIRQ 0 to 7, i.e. A to H) a PCI function's interrupt pin (INTA..INTD, pin code 0..3) drives. A small 16-byte register window holds one 16-bit route word for each programmable slot. Software writes and reads this window through a byte-addressed port with an access length of up to four bytes. A separate lookup port takes a slot number and pin and returns the selected PIRQ index one clock later.

Slots 25 to 29 and 31 are programmable. Slot 30 is a fixed bridge slot whose pins always land on PIRQ 4 to 7. Every other slot follows a rotating default that only uses the upper four lines. Every write strobe raises a one-cycle `route_changed` pulse, so that anything holding a copy of the routing knows to refresh it.

The block has no state machine. Its only sequential elements are the route bytes, the registered lookup result and the change pulse.

Top module: `pin_route_mapper`

## Requirements
- R1: After reset, each programmable route word reads 0x3210. Read as two bytes at its offset, this gives 0x00003210. The bridge word at offsets 10..11 and the spare bytes at offsets 14..15 read zero.
- R2: A lookup of slot 30 returns pin+4, whatever has been written. Its route word always reads zero, and writes to its bytes are ignored.
- R3: A lookup of any slot outside 25..31 returns ((slot + pin) mod 4) + 4, so bit 2 of the result is always set.
- R4: The route word for slot s in {25..29, 31} sits at byte offset 2*(s-25). The field for pin n occupies bits 4n+3..4n of that word. The lookup returns bits 4n+2..4n of the field, and bit 4n+3 is ignored. Route bytes change only on a write strobe.
- R5: Data is little-endian. The byte at the masked address travels on data bits 7:0, the next byte on bits 15:8, and so on. `acc_len` gives the byte count. Values 5 to 7 act as 4, and 0 touches no byte.
- R6: Only the low four address bits select a byte, so addresses that differ only above bit 3 reach the same byte.
- R7: An access that would run past offset 15 is cut short. Bytes beyond the end are neither written nor wrapped to offset 0, and their read lanes return zero.
- R8: `route_changed` is high for exactly the one cycle after each write strobe, including writes of length 0 and writes to read-only bytes. It is low otherwise.
- R9: `lk_pirq` is registered. It shows the result for the slot, pin and table contents present at the previous rising clock edge. Reads on `rd_data` are combinational.
- R10: Spare bytes 14 and 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| acc_addr | input | 8 | Byte address; only the low 4 bits are used |
| acc_len | input | 3 | Access length in bytes (0..4, larger values act as 4) |
| wr_data | input | 32 | Little-endian write data |
| rd_data | output | 32 | Little-endian read data for acc_addr/acc_len |
| route_changed | output | 1 | One-cycle pulse after each write strobe |
| lk_slot | input | 5 | Slot number for the lookup |
| lk_pin | input | 2 | Interrupt pin for the lookup (0=INTA..3=INTD) |
| lk_pirq | output | 3 | Registered PIRQ index (0..7) |

## Verification
Random writes use any address, including bits above the window, and every length 0..7. They separate correct masking, clamping and truncation from wrap-around or overrun. Random lookups over all 32 slots and four pins tell the three routing sources apart: the programmable table, the fixed bridge slot and the rotating default. Directed cases cover:
- the reset image;
- a write aimed at the bridge word;
- writes straddling the window end at offsets 13 and 15;
- a zero-length write, which must still pulse `route_changed`;
- a field whose bit 3 is set, which must be ignored.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;
    localparam int PIRQ_W  = 3;
    localparam int PIN_W   = 2;
    localparam int WORD_W  = 16;
    localparam int FIELD_W = 4;
    typedef logic [PIRQ_W-1:0] pirq_t;
    typedef logic [PIN_W-1:0]  pin_t;
    typedef logic [WORD_W-1:0] route_word_t;
endpackage

// File: rtl/pin_route_regs.sv
module pin_route_regs #(
    parameter int ADDR_W     = 8,
    parameter int WIN_BYTES  = 16,
    parameter int DATA_BYTES = 4,
    parameter int NREG       = 7,
    parameter int BRIDGE_IDX = 5,
    parameter logic [15:0] ROUTE_RST = 16'h3210,
    localparam int WIN_AW = $clog2(WIN_BYTES),
    localparam int LEN_W  = $clog2(DATA_BYTES + 1),
    localparam int DATA_W = 8 * DATA_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [LEN_W-1:0]     acc_len,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 route_changed,
    output logic [NREG*16-1:0]   route_flat
);
    logic [WIN_AW-1:0]      base;
    logic [LEN_W-1:0]       len_c;
    logic [WIN_AW:0]        lane_idx [DATA_BYTES];
    logic [DATA_BYTES-1:0]  lane_on;
    logic [8*WIN_BYTES-1:0] mem_flat;
    logic                   unused_addr_hi;

    assign base           = acc_addr[WIN_AW-1:0];
    assign unused_addr_hi = ^acc_addr;

    always_comb begin
        len_c = (acc_len > LEN_W'(DATA_BYTES)) ? LEN_W'(DATA_BYTES) : acc_len;
        for (int i = 0; i < DATA_BYTES; i++) begin
            lane_idx[i] = {1'b0, base} + (WIN_AW+1)'(i);
            lane_on[i]  = (LEN_W'(i) < len_c) && !lane_idx[i][WIN_AW];
        end
    end

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        localparam bit IS_WR = (b < 2*NREG) && ((b/2) != BRIDGE_IDX);
        if (IS_WR) begin : g_wr
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= ROUTE_RST[8*(b%2) +: 8];
                end else if (wr_en) begin
                    for (int i = 0; i < DATA_BYTES; i++) begin
                        if (lane_on[i] && lane_idx[i][WIN_AW-1:0] == WIN_AW'(b))
                            q <= wr_data[8*i +: 8];
                    end
                end
            end
            assign mem_flat[8*b +: 8] = q;
        end else begin : g_ro
            assign mem_flat[8*b +: 8] = 8'h00;
        end
    end

    always_comb begin
        for (int i = 0; i < DATA_BYTES; i++)
            rd_data[8*i +: 8] = lane_on[i] ?
                mem_flat[{lane_idx[i][WIN_AW-1:0], 3'b000} +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) route_changed <= 1'b0;
        else        route_changed <= wr_en;
    end

    assign route_flat = mem_flat[NREG*16-1:0];

    AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> route_changed);                                  // R8
    AST_CHG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !route_changed);                                // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(route_flat));                           // R4
endmodule

// File: rtl/pin_route_lookup.sv
module pin_route_lookup
    import pin_route_pkg::*;
#(
    parameter int SLOT_W     = 5,
    parameter int SLOT_BASE  = 25,
    parameter int NREG       = 7,
    parameter int BRIDGE_IDX = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG*16-1:0] route_flat,
    input  logic [SLOT_W-1:0]  lk_slot,
    input  pin_t               lk_pin,
    output pirq_t              lk_pirq
);
    route_word_t sel_word;
    logic        in_range;
    logic        is_bridge;
    pirq_t       pirq_nxt;

    always_comb begin
        sel_word  = '0;
        in_range  = 1'b0;
        is_bridge = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            if (lk_slot == SLOT_W'(SLOT_BASE + k)) begin
                in_range  = 1'b1;
                is_bridge = (k == BRIDGE_IDX);
                sel_word  = route_flat[16*k +: 16];
            end
        end
        if (is_bridge)
            pirq_nxt = {1'b1, lk_pin};
        else if (in_range)
            pirq_nxt = sel_word[int'(lk_pin)*FIELD_W +: PIRQ_W];
        else
            pirq_nxt = {1'b1, lk_slot[1:0] + lk_pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_pirq <= '0;
        else        lk_pirq <= pirq_nxt;
    end

    AST_DFLT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |=> lk_pirq[2]);                                 // R3
    AST_BRIDGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        is_bridge |=> lk_pirq == {1'b1, $past(lk_pin)});           // R2
endmodule

// File: rtl/pin_route_mapper.sv
module pin_route_mapper
    import pin_route_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int WIN_BYTES   = 16,
    parameter int DATA_BYTES  = 4,
    parameter int SLOT_W      = 5,
    parameter int SLOT_BASE   = 25,
    parameter int NREG        = 7,
    parameter int BRIDGE_SLOT = 30,
    parameter logic [15:0] ROUTE_RST = 16'h3210,
    localparam int BRIDGE_IDX = BRIDGE_SLOT - SLOT_BASE,
    localparam int LEN_W      = $clog2(DATA_BYTES + 1),
    localparam int DATA_W     = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LEN_W-1:0]  acc_len,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              route_changed,
    input  logic [SLOT_W-1:0] lk_slot,
    input  logic [PIN_W-1:0]  lk_pin,
    output logic [PIRQ_W-1:0] lk_pirq
);
    logic [NREG*16-1:0] route_flat;

    pin_route_regs #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .DATA_BYTES(DATA_BYTES),
        .NREG(NREG), .BRIDGE_IDX(BRIDGE_IDX), .ROUTE_RST(ROUTE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_addr(acc_addr),
        .acc_len(acc_len), .wr_data(wr_data), .rd_data(rd_data),
        .route_changed(route_changed), .route_flat(route_flat)
    );

    pin_route_lookup #(
        .SLOT_W(SLOT_W), .SLOT_BASE(SLOT_BASE), .NREG(NREG),
        .BRIDGE_IDX(BRIDGE_IDX)
    ) u_lookup (
        .clk(clk), .rst_n(rst_n), .route_flat(route_flat),
        .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
    );
endmodule

// File: tb/pin_route_mapper_bench.sv
module pin_route_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [2:0]  acc_len = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        route_changed;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [16];

    always #2 clk = ~clk;

    pin_route_mapper u_pin_route_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_addr(acc_addr),
        .acc_len(acc_len), .wr_data(wr_data), .rd_data(rd_data),
        .route_changed(route_changed), .lk_slot(lk_slot), .lk_pin(lk_pin),
        .lk_pirq(lk_pirq)
    );

    function automatic bit byte_writable(int b);
        return (b < 14) && (b/2 != 5);
    endfunction

    function automatic int eff_len(logic [2:0] l);
        return (l > 3'd4) ? 4 : int'(l);
    endfunction

    function automatic logic [31:0] ref_read(logic [7:0] a, logic [2:0] l);
        logic [31:0] r = '0;
        for (int i = 0; i < eff_len(l); i++)
            if (int'(a[3:0]) + i < 16) r[8*i +: 8] = model[int'(a[3:0]) + i];
        return r;
    endfunction

    function automatic logic [2:0] ref_lookup(logic [4:0] s, logic [1:0] p);
        logic [15:0] w;
        if (s == 5'd30) return {1'b1, p};
        if (s >= 5'd25) begin
            w = {model[2*(s-25)+1], model[2*(s-25)]};
            return w[4*p +: 3];
        end
        return 3'(((int'(s) + int'(p)) % 4) + 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [2:0] l, logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_len = l; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < eff_len(l); i++)
            if (int'(a[3:0]) + i < 16 && byte_writable(int'(a[3:0]) + i))
                model[int'(a[3:0]) + i] = d[8*i +: 8];
        check("R8 pulse", 32'(route_changed), 32'd1);
        @(negedge clk);
        check("R8 quiet", 32'(route_changed), 32'd0);
    endtask

    task automatic do_read(string req, logic [7:0] a, logic [2:0] l);
        acc_addr = a; acc_len = l;
        #1;
        check(req, rd_data, ref_read(a, l));
    endtask

    task automatic do_lookup(string req, logic [4:0] s, logic [1:0] p);
        @(negedge clk);
        lk_slot = s; lk_pin = p;
        @(negedge clk);
        check(req, 32'(lk_pirq), 32'(ref_lookup(s, p)));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        for (int b = 0; b < 16; b++)
            model[b] = byte_writable(b) ? ((b % 2) ? 8'h32 : 8'h10) : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset", 32'(route_changed), 32'd0);
        // R1 reset image
        for (int w = 0; w < 8; w++) do_read("R1 reset word", 8'(2*w), 3'd2);
        check("R1 explicit", {16'h0, model[1], model[0]}, 32'h00003210);
        do_lookup("R9 reset lookup", 5'd25, 2'd1);
        do_lookup("R3 default slot0", 5'd0, 2'd0);
        do_lookup("R3 default slot5", 5'd5, 2'd3);
        do_lookup("R2 bridge pin3", 5'd30, 2'd3);
        // R2 writes to the bridge word are ignored
        do_write(8'h0A, 3'd2, 32'hFFFF);
        do_read("R2 bridge reads zero", 8'h0A, 3'd2);
        do_lookup("R2 bridge pin0", 5'd30, 2'd0);
        // R4 field bit 3 ignored, R5 little-endian
        do_write(8'h02, 3'd2, 32'h0000_F9AB);
        do_lookup("R4 field masked", 5'd26, 2'd0);
        do_lookup("R4 pin3 field", 5'd26, 2'd3);
        do_read("R5 byte order", 8'h02, 3'd4);
        // R6 address masking
        do_write(8'hE4, 3'd1, 32'h0000_0055);
        do_read("R6 mask", 8'h04, 3'd1);
        // R7 truncation at window end, R10 spare bytes
        do_write(8'h0D, 3'd4, 32'h7766_5544);
        do_read("R7 trunc read", 8'h0C, 3'd4);
        do_read("R10 spare", 8'h0E, 3'd2);
        do_write(8'h0F, 3'd4, 32'h1111_1111);
        do_read("R7 no wrap", 8'h00, 3'd4);
        // R5 length 0 and length above 4
        do_write(8'h08, 3'd0, 32'hDEAD_BEEF);
        do_read("R5 len0", 8'h08, 3'd2);
        do_write(8'h00, 3'd7, 32'h0123_4567);
        do_read("R5 len clamp", 8'h00, 3'd7);
        do_lookup("R4 slot31", 5'd31, 2'd2);
        // random mix
        for (int it = 0; it < 300; it++) begin
            do_write(8'($urandom), 3'($urandom), $urandom);
            do_read("R5 random read", 8'($urandom), 3'($urandom));
            do_read("R7 random read", 8'($urandom_range(8, 15)), 3'($urandom_range(1, 4)));
            do_lookup("R4 random lookup", 5'($urandom_range(25, 31)), 2'($urandom));
            do_lookup("R3 random lookup", 5'($urandom), 2'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule